// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block walks a linked chain of transfer descriptors held in system memory and turns them into an outgoing byte stream. Once enabled and given a tail pointer, it reads each descriptor in turn through a word-wide memory port. It first checks whether the descriptor has already been consumed. If it has not, it reads the buffer the descriptor points at and packs those bytes into 32-bit stream beats. It then writes a completion status back into the descriptor and follows the chain pointer. It stops after the descriptor at the tail address, or as soon as it meets a descriptor that is already marked complete.

A frame may span several descriptors. The first descriptor of a frame carries a start flag. That flag sends five application words out on a separate side-band stream and discards any bytes left over from an unfinished frame. The last descriptor carries an end flag. It closes the frame with `tlast` and produces a one-cycle completion pulse for the interrupt logic outside the block.

Pointers are 32 bits wide, and only the low word of each 64-bit pointer field is read. Descriptors sit at a 64-byte pitch in the bench. Each descriptor has the following word offsets:
- next pointer at +0x00
- buffer address at +0x08
- control word at +0x18
- status word at +0x1C
- application words at +0x20 to +0x30

Top module: `dw_desc_walker`

## Requirements
- R1: After reset, `halted` and `idle` are 1, and `mem_req`, `m_tvalid`, `c_tvalid` and `frame_done` are 0.
- R2: The walk starts a descriptor fetch only while `run_en` is 1 and both `halted` and `idle` are 0. A `tail_ld` pulse stores the tail pointer and clears `idle`. A rising edge of `run_en` clears both `halted` and `idle`. `cur_ld` loads the current pointer only while the walker waits between descriptors.
- R3: If the status word (+0x1C) read from a descriptor has bit 31 set, the walker sets `halted` and issues no further memory request. It writes nothing back, sends no stream beat and gives no completion pulse for that descriptor.
- R4: When a descriptor's control word has bit 27 (start of frame) set, the five application words at +0x20, +0x24, +0x28, +0x2C and +0x30 are sent in that order on the side-band stream, with `c_tlast` on the fifth. Any bytes still held from an earlier unfinished frame are dropped. A valid side-band word is held stable until `c_tready`.
- R5: The transfer length is control bits [22:0], in bytes, and buffers are word-aligned. Buffer bytes are packed little-endian, with the lowest address in `m_tdata[7:0]`. Bytes carry over from one descriptor to the next within a frame, so every beat except the last of a frame is full.
- R6: Only the descriptor whose control bit 26 (end of frame) is set closes a frame. `m_tlast` is 1 on the final beat, and `m_tkeep` there has one low-order bit set per valid byte (4'hF when the frame length is a multiple of 4). Every other beat has `m_tkeep` = 4'hF and `m_tlast` = 0.
- R7: After a descriptor's data has been read, its status word (+0x1C) is written with the length in bits [22:0] and bit 31 set.
- R8: After write-back, the next pointer becomes the current pointer. If the descriptor just finished was at the tail address, `idle` is set and the walk stops. A later `tail_ld` resumes from the next pointer.
- R9: `frame_done` is a one-cycle pulse in the cycle that the status write-back of an end-of-frame descriptor is acknowledged. It does not fire for other descriptors.
- R10: When `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tkeep` and `m_tlast` hold their values, and no byte is lost or reordered.
- R11: `mem_req` holds together with a stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack`. Read data is taken on `mem_rdata` in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run enable; a rising edge clears halted and idle |
| cur_ld | input | 1 | Load the current descriptor pointer |
| cur_val | input | 32 | Current pointer value |
| tail_ld | input | 1 | Load the tail pointer and clear idle |
| tail_val | input | 32 | Tail pointer value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 32 | Read data |
| m_tvalid | output | 1 | Data stream valid |
| m_tready | input | 1 | Data stream ready |
| m_tdata | output | 32 | Data stream payload |
| m_tkeep | output | 4 | Valid byte lanes |
| m_tlast | output | 1 | Final beat of a frame |
| c_tvalid | output | 1 | Side-band stream valid |
| c_tready | input | 1 | Side-band stream ready |
| c_tdata | output | 32 | Application word |
| c_tlast | output | 1 | Fifth application word |
| halted | output | 1 | Stopped on a completed descriptor, or after reset |
| idle | output | 1 | Tail descriptor reached |
| frame_done | output | 1 | End-of-frame completion pulse |

## Verification
The bench memory acknowledges each request one cycle after it appears. As a result, `halted` rises one cycle after the acknowledged status read, and `idle` rises one cycle after the acknowledged write-back. `frame_done` is high exactly in the write-back acknowledge cycle.

Stream beats are checked by a scoreboard at the falling edge whenever valid and ready are both high, which is the transfer that completes at the next rising edge. In this way the check never depends on how many cycles the packer and the memory take.

Flags and memory words are checked only after the walker reports `idle` or `halted` with no request pending. That point is when every write-back for the chain has already landed.

// File: rtl/dw_pkg.sv
package dw_pkg;

    typedef enum logic [3:0] {
        W_WAIT,
        W_FETCH,
        W_APP_RD,
        W_APP_OUT,
        W_DATA,
        W_BUF_RD,
        W_EMIT,
        W_FLUSH,
        W_WB
    } walk_st_e;

    // byte offsets inside one descriptor
    localparam int OFS_NEXT = 0;
    localparam int OFS_BUF  = 8;
    localparam int OFS_CTRL = 24;
    localparam int OFS_STAT = 28;
    localparam int OFS_APP  = 32;

    // control / status bit positions
    localparam int CTRL_EOF_BIT  = 26;
    localparam int CTRL_SOF_BIT  = 27;
    localparam int STAT_DONE_BIT = 31;

endpackage

// File: rtl/dw_runstate.sv
module dw_runstate #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              tail_ld,
    input  logic [ADDR_W-1:0] tail_val,
    input  logic              set_halt,
    input  logic              set_idle,
    output logic              halted,
    output logic              idle,
    output logic              go,
    output logic [ADDR_W-1:0] tail_ptr
);

    typedef struct packed {
        logic              run;
        logic              halted;
        logic              idle;
        logic [ADDR_W-1:0] tail;
    } rs_t;

    rs_t rs_d, rs_q;

    always_comb begin
        rs_d     = rs_q;
        rs_d.run = run_en;
        if (set_halt) rs_d.halted = 1'b1;
        if (set_idle) rs_d.idle   = 1'b1;
        if (run_en && !rs_q.run) begin
            rs_d.halted = 1'b0;
            rs_d.idle   = 1'b0;
        end
        if (tail_ld) begin
            rs_d.tail = tail_val;
            rs_d.idle = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q.run    <= 1'b0;
            rs_q.halted <= 1'b1;
            rs_q.idle   <= 1'b1;
            rs_q.tail   <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign halted   = rs_q.halted;
    assign idle     = rs_q.idle;
    assign tail_ptr = rs_q.tail;
    assign go       = run_en && !rs_q.halted && !rs_q.idle;

    AST_TAIL_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        tail_ld |=> !idle);                                   // R2
    AST_RUN_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !rs_q.run) |=> !halted);                   // R2

endmodule

// File: rtl/dw_packer.sv
module dw_packer #(
    parameter int BYTES = 4,
    localparam int WORD_W = BYTES * 8,
    localparam int CNT_W  = $clog2(2 * BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic [CNT_W-1:0]  push_n,
    input  logic              pop,
    output logic [CNT_W-1:0]  cnt,
    output logic [WORD_W-1:0] out_word,
    output logic [BYTES-1:0]  out_keep
);

    localparam int HOLD_W = 2 * WORD_W;

    typedef struct packed {
        logic [HOLD_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
    } pk_t;

    pk_t pk_d, pk_q;
    logic [WORD_W-1:0] masked;

    always_comb begin
        masked = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (CNT_W'(i) < push_n) masked[i*8 +: 8] = push_word[i*8 +: 8];
        end
    end

    always_comb begin
        pk_d = pk_q;
        if (clr) begin
            pk_d.data = '0;
            pk_d.cnt  = '0;
        end else if (pop) begin
            pk_d.data = pk_q.data >> WORD_W;
            pk_d.cnt  = (pk_q.cnt >= CNT_W'(BYTES)) ? pk_q.cnt - CNT_W'(BYTES) : '0;
        end else if (push) begin
            pk_d.data = pk_q.data | (HOLD_W'(masked) << (pk_q.cnt * 8));
            pk_d.cnt  = pk_q.cnt + push_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pk_q <= '0;
        end else begin
            pk_q <= pk_d;
        end
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_keep
        assign out_keep[g] = (pk_q.cnt > CNT_W'(g));
    end

    assign cnt      = pk_q.cnt;
    assign out_word = pk_q.data[WORD_W-1:0];

    AST_PACK_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (pk_q.cnt < CNT_W'(BYTES)));                 // R5

endmodule

// File: rtl/dw_desc_walker.sv
module dw_desc_walker
    import dw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 23,
    parameter int APP_WORDS = 5,
    parameter int WORD_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              cur_ld,
    input  logic [ADDR_W-1:0] cur_val,
    input  logic              tail_ld,
    input  logic [ADDR_W-1:0] tail_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [WORD_W-1:0] m_tdata,
    output logic [WORD_W/8-1:0] m_tkeep,
    output logic              m_tlast,
    output logic              c_tvalid,
    input  logic              c_tready,
    output logic [WORD_W-1:0] c_tdata,
    output logic              c_tlast,
    output logic              halted,
    output logic              idle,
    output logic              frame_done
);

    localparam int BYTES = WORD_W / 8;
    localparam int CNT_W = $clog2(2 * BYTES);
    localparam int IDX_W = (APP_WORDS > 4) ? $clog2(APP_WORDS) : 2;

    typedef struct packed {
        walk_st_e          st;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] bufp;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  rem;
        logic              sof;
        logic              eof;
        logic [WORD_W-1:0] app;
    } walk_t;

    walk_t w_d, w_q;

    logic              go, set_halt, set_idle;
    logic [ADDR_W-1:0] tail_ptr;
    logic              pk_clr, pk_push, pk_pop;
    logic [CNT_W-1:0]  push_n, pk_cnt;
    logic [WORD_W-1:0] pk_word;
    logic [BYTES-1:0]  pk_keep;

    // fetch order: status first so a consumed descriptor stops early
    function automatic logic [ADDR_W-1:0] fetch_ofs(input logic [IDX_W-1:0] i);
        case (i)
            IDX_W'(0): fetch_ofs = ADDR_W'(OFS_STAT);
            IDX_W'(1): fetch_ofs = ADDR_W'(OFS_CTRL);
            IDX_W'(2): fetch_ofs = ADDR_W'(OFS_NEXT);
            default:   fetch_ofs = ADDR_W'(OFS_BUF);
        endcase
    endfunction

    dw_runstate #(.ADDR_W(ADDR_W)) u_runstate (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .tail_ld  (tail_ld),
        .tail_val (tail_val),
        .set_halt (set_halt),
        .set_idle (set_idle),
        .halted   (halted),
        .idle     (idle),
        .go       (go),
        .tail_ptr (tail_ptr)
    );

    dw_packer #(.BYTES(BYTES)) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pk_clr),
        .push      (pk_push),
        .push_word (mem_rdata),
        .push_n    (push_n),
        .pop       (pk_pop),
        .cnt       (pk_cnt),
        .out_word  (pk_word),
        .out_keep  (pk_keep)
    );

    always_comb begin
        w_d        = w_q;
        set_halt   = 1'b0;
        set_idle   = 1'b0;
        pk_clr     = 1'b0;
        pk_push    = 1'b0;
        pk_pop     = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = w_q.cur;
        mem_wdata  = '0;
        m_tvalid   = 1'b0;
        m_tlast    = 1'b0;
        m_tkeep    = '1;
        c_tvalid   = 1'b0;
        c_tlast    = 1'b0;
        frame_done = 1'b0;
        push_n     = (w_q.rem >= LEN_W'(BYTES)) ? CNT_W'(BYTES) : CNT_W'(w_q.rem);

        unique case (w_q.st)
            W_WAIT: begin
                if (cur_ld) begin
                    w_d.cur = cur_val;
                end else if (go) begin
                    w_d.st  = W_FETCH;
                    w_d.idx = '0;
                end
            end

            W_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = w_q.cur + fetch_ofs(w_q.idx);
                if (mem_ack) begin
                    w_d.idx = w_q.idx + IDX_W'(1);
                    case (w_q.idx)
                        IDX_W'(0): begin
                            if (mem_rdata[STAT_DONE_BIT]) begin
                                set_halt = 1'b1;
                                w_d.st   = W_WAIT;
                            end
                        end
                        IDX_W'(1): begin
                            w_d.len = mem_rdata[LEN_W-1:0];
                            w_d.rem = mem_rdata[LEN_W-1:0];
                            w_d.sof = mem_rdata[CTRL_SOF_BIT];
                            w_d.eof = mem_rdata[CTRL_EOF_BIT];
                        end
                        IDX_W'(2): w_d.nxt = mem_rdata[ADDR_W-1:0];
                        default: begin
                            w_d.bufp = mem_rdata[ADDR_W-1:0];
                            w_d.idx  = '0;
                            if (w_q.sof) begin
                                pk_clr = 1'b1;
                                w_d.st = W_APP_RD;
                            end else begin
                                w_d.st = W_DATA;
                            end
                        end
                    endcase
                end
            end

            W_APP_RD: begin
                mem_req  = 1'b1;
                mem_addr = w_q.cur + ADDR_W'(OFS_APP) + (ADDR_W'(w_q.idx) << 2);
                if (mem_ack) begin
                    w_d.app = mem_rdata;
                    w_d.st  = W_APP_OUT;
                end
            end

            W_APP_OUT: begin
                c_tvalid = 1'b1;
                c_tlast  = (w_q.idx == IDX_W'(APP_WORDS - 1));
                if (c_tready) begin
                    if (c_tlast) begin
                        w_d.st = W_DATA;
                    end else begin
                        w_d.idx = w_q.idx + IDX_W'(1);
                        w_d.st  = W_APP_RD;
                    end
                end
            end

            W_DATA: begin
                if (pk_cnt >= CNT_W'(BYTES))           w_d.st = W_EMIT;
                else if (w_q.rem != '0)                w_d.st = W_BUF_RD;
                else if (w_q.eof && pk_cnt != '0)      w_d.st = W_FLUSH;
                else                                   w_d.st = W_WB;
            end

            W_BUF_RD: begin
                mem_req  = 1'b1;
                mem_addr = w_q.bufp;
                if (mem_ack) begin
                    pk_push  = 1'b1;
                    w_d.rem  = w_q.rem - LEN_W'(push_n);
                    w_d.bufp = w_q.bufp + ADDR_W'(BYTES);
                    w_d.st   = W_DATA;
                end
            end

            W_EMIT: begin
                m_tvalid = 1'b1;
                m_tlast  = w_q.eof && (w_q.rem == '0) && (pk_cnt == CNT_W'(BYTES));
                if (m_tready) begin
                    pk_pop = 1'b1;
                    w_d.st = W_DATA;
                end
            end

            W_FLUSH: begin
                m_tvalid = 1'b1;
                m_tlast  = 1'b1;
                m_tkeep  = pk_keep;
                if (m_tready) begin
                    pk_pop = 1'b1;
                    w_d.st = W_WB;
                end
            end

            W_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = w_q.cur + ADDR_W'(OFS_STAT);
                mem_wdata[LEN_W-1:0]     = w_q.len;
                mem_wdata[STAT_DONE_BIT] = 1'b1;
                if (mem_ack) begin
                    frame_done = w_q.eof;
                    set_idle   = (w_q.cur == tail_ptr);
                    w_d.cur    = w_q.nxt;
                    w_d.st     = W_WAIT;
                end
            end

            default: w_d.st = W_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q    <= '0;
            w_q.st <= W_WAIT;
        end else begin
            w_q <= w_d;
        end
    end

    assign m_tdata = pk_word;
    assign c_tdata = w_q.app;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));            // R11
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)
                                     && $stable(m_tkeep) && $stable(m_tlast))); // R10
    AST_SIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (c_tvalid && !c_tready) |=> (c_tvalid && $stable(c_tdata) && $stable(c_tlast))); // R4
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_req && !m_tvalid && !c_tvalid));             // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);                                   // R9
    AST_KEEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> ((m_tkeep != '0) && (((m_tkeep + 1'b1) & m_tkeep) == '0))); // R6
    AST_PARTIAL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !(&m_tkeep)) |-> m_tlast);                        // R6

endmodule

// File: tb/tb_dw_desc_walker.sv
module tb_dw_desc_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run_en, cur_ld, tail_ld;
    logic [31:0] cur_val, tail_val;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        m_tvalid, m_tready, m_tlast;
    logic [31:0] m_tdata;
    logic [3:0]  m_tkeep;
    logic        c_tvalid, c_tready, c_tlast;
    logic [31:0] c_tdata;
    logic        halted, idle, frame_done;

    always #10 clk = ~clk;

    dw_desc_walker dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .cur_ld(cur_ld), .cur_val(cur_val), .tail_ld(tail_ld), .tail_val(tail_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tkeep(m_tkeep), .m_tlast(m_tlast),
        .c_tvalid(c_tvalid), .c_tready(c_tready), .c_tdata(c_tdata), .c_tlast(c_tlast),
        .halted(halted), .idle(idle), .frame_done(frame_done)
    );

    int checks = 0, fails = 0;
    int done_cnt = 0, req_cnt = 0, cyc = 0;
    bit stall = 1'b0;

    logic [31:0] mem [0:8191];
    logic [36:0] exp_q[$];   // {data, keep, last}
    logic [32:0] expc_q[$];  // {last, data}
    logic [7:0]  bq[$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input logic [31:0] a);
        return a[7:0] * 8'd37 + 8'd11;
    endfunction

    function automatic logic [31:0] appw(input logic [31:0] a, input int k);
        return {a[15:0], 16'hA000 + 16'(k)};
    endfunction

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[int'(mem_addr >> 2)] <= mem_wdata;
            else        mem_rdata <= mem[int'(mem_addr >> 2)];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // ready pattern, changed away from the edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2;
        m_tready = stall ? (cyc % 3 != 0) : 1'b1;
        c_tready = stall ? (cyc % 2 == 0) : 1'b1;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_done) done_cnt++;
            if (mem_req) req_cnt++;
            if (m_tvalid && m_tready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected data beat", {m_tdata, m_tkeep}, 0);
                end else begin
                    logic [36:0] e;
                    logic [31:0] km;
                    e = exp_q.pop_front();
                    for (int i = 0; i < 4; i++) km[i*8 +: 8] = {8{e[i+1]}};
                    chk(((m_tdata & km) == (e[36:5] & km)) && m_tkeep == e[4:1]
                        && m_tlast == e[0], "R5 R6 R10 data beat",
                        {m_tdata & km, m_tkeep, m_tlast}, {e[36:5] & km, e[4:0]});
                end
            end
            if (c_tvalid && c_tready) begin
                if (expc_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected side-band word", c_tdata, 0);
                end else begin
                    logic [32:0] e;
                    e = expc_q.pop_front();
                    chk(c_tdata == e[31:0] && c_tlast == e[32], "R4 side-band word",
                        {c_tlast, c_tdata}, e);
                end
            end
        end
    end

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt,
                            input logic [31:0] bufa, input int len,
                            input bit sof, input bit eof, input logic [31:0] stat);
        int b;
        b = int'(a >> 2);
        mem[b+0] = nxt;  mem[b+1] = 0;
        mem[b+2] = bufa; mem[b+3] = 0;
        mem[b+4] = 0;    mem[b+5] = 0;
        mem[b+6] = 32'(len) | (32'(eof) << 26) | (32'(sof) << 27);
        mem[b+7] = stat;
        for (int k = 0; k < 5; k++) mem[b+8+k] = appw(a, k);
        for (int w = 0; w < (len + 3) / 4; w++)
            for (int i = 0; i < 4; i++)
                mem[int'(bufa >> 2) + w][i*8 +: 8] = bval(bufa + 32'(w*4 + i));
    endtask

    task automatic exp_apps(input logic [31:0] a);
        for (int k = 0; k < 5; k++) expc_q.push_back({k == 4, appw(a, k)});
    endtask

    task automatic exp_bytes(input logic [31:0] bufa, input int len);
        for (int i = 0; i < len; i++) bq.push_back(bval(bufa + 32'(i)));
    endtask

    task automatic exp_frame_end();
        while (bq.size() > 0) begin
            logic [31:0] d;
            logic [3:0]  k;
            d = 0; k = 0;
            for (int i = 0; i < 4; i++) begin
                if (bq.size() > 0) begin
                    d[i*8 +: 8] = bq.pop_front();
                    k[i] = 1'b1;
                end
            end
            exp_q.push_back({d, k, bq.size() == 0});
        end
    endtask

    task automatic pulse_tail(input logic [31:0] a);
        @(negedge clk); tail_ld = 1'b1; tail_val = a;
        @(negedge clk); tail_ld = 1'b0;
    endtask

    task automatic wait_stop();
        int n;
        n = 0;
        repeat (3) @(negedge clk);
        while (!((idle || halted) && !mem_req) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 3000, "R8 walk reaches a stop", n, 0);
    endtask

    task automatic chk_drained(input string tag);
        chk(exp_q.size() == 0 && expc_q.size() == 0, tag, exp_q.size(), expc_q.size());
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; run_en = 1'b0; cur_ld = 1'b0; tail_ld = 1'b0;
        cur_val = 0; tail_val = 0; m_tready = 1'b1; c_tready = 1'b1;
        for (int i = 0; i < 8192; i++) mem[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(halted == 1'b1, "R1 halted after reset", halted, 1);
        chk(idle == 1'b1, "R1 idle after reset", idle, 1);
        chk(mem_req == 1'b0, "R1 no memory request", mem_req, 0);
        chk(!m_tvalid && !c_tvalid, "R1 streams quiet", {m_tvalid, c_tvalid}, 0);
        chk(frame_done == 1'b0, "R1 no completion pulse", frame_done, 0);

        // A: single descriptor; nothing happens while run is low
        put_desc(32'h100, 32'h140, 32'h1000, 10, 1'b1, 1'b1, 0);
        @(negedge clk); cur_ld = 1'b1; cur_val = 32'h100;
        @(negedge clk); cur_ld = 1'b0;
        pulse_tail(32'h100);
        req_cnt = 0;
        repeat (20) @(negedge clk);
        chk(req_cnt == 0, "R2 no fetch while run low", req_cnt, 0);
        exp_apps(32'h100); exp_bytes(32'h1000, 10); exp_frame_end();
        run_en = 1'b1;
        wait_stop();
        chk(mem[(32'h100 >> 2) + 7] == (32'd10 | 32'h8000_0000), "R7 status write-back",
            mem[(32'h100 >> 2) + 7], 32'd10 | 32'h8000_0000);
        chk(done_cnt == 1, "R9 one completion pulse", done_cnt, 1);
        chk(idle == 1'b1 && halted == 1'b0, "R8 idle at tail", {idle, halted}, 2'b10);
        chk_drained("R4 R5 all beats of frame A seen");

        // B: one frame across three descriptors, with back-pressure
        stall = 1'b1;
        put_desc(32'h140, 32'h180, 32'h1100, 5, 1'b1, 1'b0, 0);
        put_desc(32'h180, 32'h1C0, 32'h1200, 6, 1'b0, 1'b0, 0);
        put_desc(32'h1C0, 32'h200, 32'h1300, 3, 1'b0, 1'b1, 0);
        exp_apps(32'h140);
        exp_bytes(32'h1100, 5); exp_bytes(32'h1200, 6); exp_bytes(32'h1300, 3);
        exp_frame_end();
        pulse_tail(32'h1C0);
        wait_stop();
        chk(mem[(32'h180 >> 2) + 7] == (32'd6 | 32'h8000_0000), "R7 middle status",
            mem[(32'h180 >> 2) + 7], 32'd6 | 32'h8000_0000);
        chk(mem[(32'h1C0 >> 2) + 7] == (32'd3 | 32'h8000_0000), "R7 last status",
            mem[(32'h1C0 >> 2) + 7], 32'd3 | 32'h8000_0000);
        chk(done_cnt == 2, "R9 one pulse for three descriptors", done_cnt, 2);
        chk_drained("R5 R10 multi-descriptor frame complete");

        // C: tail stop, then resume from the next pointer
        stall = 1'b0;
        put_desc(32'h200, 32'h240, 32'h1400, 8, 1'b1, 1'b1, 0);
        put_desc(32'h240, 32'h280, 32'h1500, 4, 1'b1, 1'b1, 0);
        exp_apps(32'h200); exp_bytes(32'h1400, 8); exp_frame_end();
        pulse_tail(32'h200);
        wait_stop();
        chk(mem[(32'h240 >> 2) + 7] == 0, "R8 descriptor past tail untouched",
            mem[(32'h240 >> 2) + 7], 0);
        chk(done_cnt == 3, "R9 pulse count after tail stop", done_cnt, 3);
        chk_drained("R6 full-word last beat");
        exp_apps(32'h240); exp_bytes(32'h1500, 4); exp_frame_end();
        pulse_tail(32'h240);
        wait_stop();
        chk(mem[(32'h240 >> 2) + 7] == (32'd4 | 32'h8000_0000), "R8 resume from next",
            mem[(32'h240 >> 2) + 7], 32'd4 | 32'h8000_0000);
        chk(done_cnt == 4, "R9 pulse count after resume", done_cnt, 4);
        chk_drained("R6 resumed frame complete");

        // D: already-complete descriptor halts the walk
        put_desc(32'h280, 32'h2C0, 32'h1600, 7, 1'b1, 1'b1, 32'h8000_0055);
        pulse_tail(32'h280);
        wait_stop();
        repeat (5) @(negedge clk);
        chk(halted == 1'b1, "R3 halted on complete descriptor", halted, 1);
        chk(mem[(32'h280 >> 2) + 7] == 32'h8000_0055, "R3 no write-back",
            mem[(32'h280 >> 2) + 7], 32'h8000_0055);
        chk(done_cnt == 4, "R3 no completion pulse", done_cnt, 4);
        chk(mem_req == 1'b0, "R3 no request after halt", mem_req, 0);
        chk_drained("R3 no stream output");

        // E: a new start of frame drops an unfinished frame's bytes
        put_desc(32'h280, 32'h2C0, 32'h1600, 3, 1'b1, 1'b0, 0);
        put_desc(32'h2C0, 32'h300, 32'h1700, 2, 1'b1, 1'b1, 0);
        exp_apps(32'h280); exp_apps(32'h2C0);
        exp_bytes(32'h1700, 2); exp_frame_end();
        pulse_tail(32'h2C0);
        @(negedge clk); run_en = 1'b0;
        @(negedge clk); run_en = 1'b1;
        wait_stop();
        chk(halted == 1'b0 && idle == 1'b1, "R2 run rise clears halt", {halted, idle}, 2'b01);
        chk(mem[(32'h280 >> 2) + 7] == (32'd3 | 32'h8000_0000), "R7 unfinished frame status",
            mem[(32'h280 >> 2) + 7], 32'd3 | 32'h8000_0000);
        chk(done_cnt == 5, "R9 only end-of-frame pulses", done_cnt, 5);
        chk_drained("R4 stale bytes dropped on new frame");

        summary();
        $finish;
    end

endmodule